// File: doc/BRIEF.md
# Clock and Reset Domain Control Register Block

This block is the software-facing register file of a clock and reset domain. A 32-bit register bus reaches a one-bit interrupt status, an interrupt mask, a processor-cluster reset register and a small set of clock-configuration words. The block drives one level interrupt and two per-core pulse vectors that a power sequencer uses to switch cores off or bring them back on through reset.

The interrupt mask cannot be written directly. Software clears mask bits through an enable alias and sets them through a disable alias. Each core has one bit in the cluster reset register. A bit that rises produces a power-off pulse for that core, and a bit that falls produces a power-on-with-reset pulse. Bits written with their current value produce nothing. The PLL, divider and gating words are plain storage, each with its own reset value and reserved bits. The PLL status word is a constant.

Top module: `crr_regblk`

Word map, as byte addresses on `addr_i`: 0x00 interrupt status, 0x04 mask, 0x08 mask-enable alias, 0x0C mask-disable alias, 0x10 PLL status, 0x14 cluster reset, 0x20/0x24/0x28 clock words 0/1/2.

## Requirements
- R1: After reset the words read as follows: status 0, mask 1, PLL status 0x3f, cluster reset 0x3d0f, clock word 0 0x12c09, clock word 1 0, clock word 2 0x1002300. After reset `irq_o` is low and both pulse vectors are zero.
- R2: `irq_o` is high exactly when status bit 0 is 1 and mask bit 0 is 0. It follows a register change from the clock edge that makes the change.
- R3: `evt_i` high at an edge sets status bit 0. A write of 1 in bit 0 to 0x00 clears it. If both happen at the same edge, the set wins.
- R4: Writes to the mask word at 0x04 are accepted without error and have no effect.
- R5: A write to 0x08 with bit 0 = 1 clears the mask. A write to 0x0C with bit 0 = 1 sets it. Both alias words read as 0.
- R6: An access is legal only when `be_i` is 4'hf and `addr_i[1:0]` is 0. Otherwise the block answers with an error, returns zero data and changes nothing.
- R7: An address outside the word map answers with an error and zero data.
- R8: Every request is answered exactly one cycle later by `rsp_valid_o`, together with `err_o` and `rdata_o`. A write answers with zero data.
- R9: Reserved bits read as 0 and ignore writes. The reserved masks are 0xf88c80f6 for clock word 0, 0x01801210 for clock word 1, 0xfec0c0f8 for clock word 2 and 0xffffc2f0 for cluster reset. All bits except bit 0 are reserved in status and mask.
- R10: Cluster reset bits 3:0 belong to cores 3:0. In the cycle after a write, `core_off_o[i]` pulses for one cycle if bit i went from 0 to 1, and `core_on_rst_o[i]` pulses if it went from 1 to 0. Unchanged bits give no pulse.
- R11: The PLL status word always reads 0x3f, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| be_i | input | 4 | Byte enables; must be all ones |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rdata_o | output | 32 | Read data, valid with rsp_valid_o |
| err_o | output | 1 | Slave error, valid with rsp_valid_o |
| evt_i | input | 1 | Interrupt event; sets status bit 0 |
| irq_o | output | 1 | Level interrupt |
| core_off_o | output | N_CORE | Per-core power-off pulses |
| core_on_rst_o | output | N_CORE | Per-core power-on-and-reset pulses |

## Verification
The hardest case to reach is an event and a clearing write that land on the same edge. The bench forces it by raising `evt_i` in the same cycle as the write request to 0x00. A second hard case is a single cluster-reset write that raises one core bit and lowers another at once, so both pulse vectors fire in the same cycle. The bench reaches it with a chain of writes that walks the reset word through all-ones, zero, 0x5 (written twice) and 0x3. A behavioural model runs next to the design and is compared against every output on every clock.

// File: rtl/crr_pkg.sv
package crr_pkg;
  localparam int DW     = 32;
  localparam int N_CLK  = 3;
  localparam int CLK_BASE = 8;

  localparam logic [DW-1:0] PLL_STAT_VAL = 32'h0000_003f;
  localparam logic [DW-1:0] CPU_RST_VAL  = 32'h0000_3d0f;
  localparam logic [DW-1:0] CPU_RSVD     = 32'hffff_c2f0;

  localparam logic [DW-1:0] CLK_RST  [N_CLK] = '{32'h0001_2c09, 32'h0000_0000, 32'h0100_2300};
  localparam logic [DW-1:0] CLK_RSVD [N_CLK] = '{32'hf88c_80f6, 32'h0180_1210, 32'hfec0_c0f8};

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_MASK, SEL_EN, SEL_DIS, SEL_PSTAT, SEL_CPU, SEL_CLK
  } sel_e;
endpackage

// File: rtl/crr_decode.sv
module crr_decode
  import crr_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 2,
  localparam int CI_W  = (N_CLK > 1) ? $clog2(N_CLK) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  output sel_e              sel_o,
  output logic [CI_W-1:0]   clk_idx_o,
  output logic              ok_o
);
  logic [IDX_W-1:0] idx, rel;

  assign idx = addr_i[ADDR_W-1:2];
  assign rel = idx - IDX_W'(CLK_BASE);
  assign clk_idx_o = rel[CI_W-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (idx >= IDX_W'(CLK_BASE) && idx < IDX_W'(CLK_BASE + N_CLK)) sel_o = SEL_CLK;
    else begin
      case (idx)
        IDX_W'(0): sel_o = SEL_STAT;
        IDX_W'(1): sel_o = SEL_MASK;
        IDX_W'(2): sel_o = SEL_EN;
        IDX_W'(3): sel_o = SEL_DIS;
        IDX_W'(4): sel_o = SEL_PSTAT;
        IDX_W'(5): sel_o = SEL_CPU;
        default:   sel_o = SEL_NONE;
      endcase
    end
  end

  // word-only: full byte enables, aligned, decoded
  assign ok_o = (be_i == 4'hf) && (addr_i[1:0] == 2'b00) && (sel_o != SEL_NONE);
endmodule

// File: rtl/crr_irq.sv
module crr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic dis_i,
  output logic status_o,
  output logic mask_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= 1'b0;
      mask_o   <= 1'b1;
    end else begin
      if (evt_i)      status_o <= 1'b1;   // set beats clear
      else if (clr_i) status_o <= 1'b0;
      if (dis_i)      mask_o <= 1'b1;
      else if (en_i)  mask_o <= 1'b0;
    end
  end

  assign irq_o = status_o & ~mask_o;

  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> status_o);
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !status_o);
  a_r5_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !dis_i) |=> !mask_o);
  a_r5_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> mask_o);
endmodule

// File: rtl/crr_core_rst.sv
module crr_core_rst
  import crr_pkg::*;
#(
  parameter int N_CORE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     value_o,
  output logic [N_CORE-1:0] off_o,
  output logic [N_CORE-1:0] on_o
);
  logic [DW-1:0] nxt;
  assign nxt = wdata_i & ~CPU_RSVD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_o <= CPU_RST_VAL;
      off_o   <= '0;
      on_o    <= '0;
    end else begin
      off_o <= '0;
      on_o  <= '0;
      if (we_i) begin
        value_o <= nxt;
        off_o   <= nxt[N_CORE-1:0] & ~value_o[N_CORE-1:0];
        on_o    <= ~nxt[N_CORE-1:0] & value_o[N_CORE-1:0];
      end
    end
  end

  a_r10_off_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|off_o) |=> ((off_o & $past(off_o)) == '0));
  a_r10_on_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|on_o) |=> ((on_o & $past(on_o)) == '0));
  a_r10_off_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((off_o & ~value_o[N_CORE-1:0]) == '0));
  a_r10_on_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((on_o & value_o[N_CORE-1:0]) == '0));
  a_r10_no_write_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (off_o == '0 && on_o == '0));
endmodule

// File: rtl/crr_store.sv
module crr_store
  import crr_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter logic [DW-1:0] RSVD    = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL & ~RSVD;
    else if (we_i) q_o <= wdata_i & ~RSVD;
  end

  a_r9_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o & RSVD) == '0));
endmodule

// File: rtl/crr_regblk.sv
module crr_regblk
  import crr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_CORE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  input  logic              evt_i,
  output logic              irq_o,
  output logic [N_CORE-1:0] core_off_o,
  output logic [N_CORE-1:0] core_on_rst_o
);
  localparam int CI_W = (N_CLK > 1) ? $clog2(N_CLK) : 1;

  sel_e            sel;
  logic [CI_W-1:0] clk_idx;
  logic            ok, wr;
  logic            status, mask;
  logic [DW-1:0]   cpu_val, rd_mux;
  logic [DW-1:0]   clk_q [N_CLK];

  crr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .be_i(be_i), .sel_o(sel), .clk_idx_o(clk_idx), .ok_o(ok)
  );

  assign wr = req_i & we_i & ok;

  crr_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
    .clr_i(wr && sel == SEL_STAT && wdata_i[0]),
    .en_i (wr && sel == SEL_EN   && wdata_i[0]),
    .dis_i(wr && sel == SEL_DIS  && wdata_i[0]),
    .status_o(status), .mask_o(mask), .irq_o(irq_o)
  );

  crr_core_rst #(.N_CORE(N_CORE)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr && sel == SEL_CPU),
    .wdata_i(wdata_i), .value_o(cpu_val), .off_o(core_off_o), .on_o(core_on_rst_o)
  );

  for (genvar g = 0; g < N_CLK; g++) begin : g_clk
    crr_store #(.RST_VAL(CLK_RST[g]), .RSVD(CLK_RSVD[g])) u_store (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .we_i(wr && sel == SEL_CLK && clk_idx == CI_W'(g)),
      .wdata_i(wdata_i), .q_o(clk_q[g])
    );
  end

  always_comb begin
    case (sel)
      SEL_STAT:  rd_mux = {{(DW-1){1'b0}}, status};
      SEL_MASK:  rd_mux = {{(DW-1){1'b0}}, mask};
      SEL_PSTAT: rd_mux = PLL_STAT_VAL;
      SEL_CPU:   rd_mux = cpu_val;
      SEL_CLK:   rd_mux = clk_q[clk_idx];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      err_o       <= req_i & ~ok;
      rdata_o     <= (req_i && !we_i && ok) ? rd_mux : '0;
    end
  end

  a_r8_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rsp_valid_o && !err_o));
  a_r7_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  a_r6_bad_be_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && be_i != 4'hf) |=> err_o);
  a_r2_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(evt_i) || $past(wr && sel == SEL_EN)));
endmodule

// File: tb/crr_regblk_test.sv
module crr_regblk_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0, evt = 0;
  logic [7:0]  addr = 0;
  logic [3:0]  be = 0;
  logic [31:0] wd = 0;
  logic        rsp_valid, err, irq;
  logic [31:0] rdata;
  logic [3:0]  off, on_rst;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R1";
  logic [31:0] lrd;
  logic        lerr;

  crr_regblk uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wd), .rsp_valid_o(rsp_valid), .rdata_o(rdata), .err_o(err),
    .evt_i(evt), .irq_o(irq), .core_off_o(off), .core_on_rst_o(on_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic        m_st, m_mk, m_rv, m_err;
  logic [31:0] m_cpu, m_rd, m_nv, m_rdv;
  logic [31:0] m_clk [3];
  logic [3:0]  m_off, m_on;
  int          m_w;
  bit          m_ok;
  localparam logic [31:0] RSV0 = 32'hf88c80f6, RSV1 = 32'h01801210, RSV2 = 32'hfec0c0f8;

  function automatic logic [31:0] rsv(int i);
    return (i == 0) ? RSV0 : (i == 1) ? RSV1 : RSV2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_mk = 1; m_cpu = 32'h3d0f;
      m_clk[0] = 32'h12c09; m_clk[1] = 0; m_clk[2] = 32'h1002300;
      m_off = 0; m_on = 0; m_rv = 0; m_err = 0; m_rd = 0;
    end else begin
      m_w  = int'(addr[7:2]);
      m_ok = (be == 4'hf) && (addr[1:0] == 0) && (m_w <= 5 || (m_w >= 8 && m_w <= 10));
      case (m_w)
        0: m_rdv = {31'b0, m_st};
        1: m_rdv = {31'b0, m_mk};
        4: m_rdv = 32'h3f;
        5: m_rdv = m_cpu;
        8, 9, 10: m_rdv = m_clk[m_w-8];
        default: m_rdv = 0;
      endcase
      m_off = 0; m_on = 0;
      m_rv  = req;
      m_err = req && !m_ok;
      m_rd  = (req && !we && m_ok) ? m_rdv : 0;
      if (req && we && m_ok) begin
        case (m_w)
          0: if (wd[0]) m_st = 0;
          2: if (wd[0]) m_mk = 0;
          3: if (wd[0]) m_mk = 1;
          5: begin
            m_nv  = wd & 32'h3d0f;
            m_off = m_nv[3:0] & ~m_cpu[3:0];
            m_on  = ~m_nv[3:0] & m_cpu[3:0];
            m_cpu = m_nv;
          end
          8, 9, 10: m_clk[m_w-8] = wd & ~rsv(m_w-8);
          default: ;
        endcase
      end
      if (evt) m_st = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk({cur_tag, " R2 irq"}, {31'b0, irq}, {31'b0, m_st & ~m_mk});
    chk({cur_tag, " R10 off"}, {28'b0, off}, {28'b0, m_off});
    chk({cur_tag, " R10 on"}, {28'b0, on_rst}, {28'b0, m_on});
    chk({cur_tag, " R8 valid"}, {31'b0, rsp_valid}, {31'b0, m_rv});
    chk({cur_tag, " R7 err"}, {31'b0, err}, {31'b0, m_err});
    chk({cur_tag, " R8 rdata"}, rdata, m_rd);
  end

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk); req = 1; we = w; addr = a; wd = d; be = b;
    @(negedge clk); req = 0; we = 0; lrd = rdata; lerr = err;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus(0, a, 0, 4'hf);
    chk(tag, lrd, exp);
    chk({tag, " err"}, {31'b0, lerr}, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus(1, a, d, 4'hf);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R1";
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pulses", {24'b0, off, on_rst}, 0);
    rd(8'h00, 32'h0, "R1 status");
    rd(8'h04, 32'h1, "R1 mask");
    rd(8'h10, 32'h3f, "R1 pll status");
    rd(8'h14, 32'h3d0f, "R1 cluster reset");
    rd(8'h20, 32'h12c09, "R1 clk0");
    rd(8'h24, 32'h0, "R1 clk1");
    rd(8'h28, 32'h1002300, "R1 clk2");

    cur_tag = "R3";
    @(negedge clk); evt = 1; @(negedge clk); evt = 0;
    chk("R2 masked irq", {31'b0, irq}, 0);
    rd(8'h00, 32'h1, "R3 status set");
    cur_tag = "R5";
    wr(8'h08, 32'h1);
    chk("R2 irq after enable", {31'b0, irq}, 1);
    rd(8'h04, 32'h0, "R5 mask cleared");
    rd(8'h08, 32'h0, "R5 enable alias reads 0");
    cur_tag = "R3";
    wr(8'h00, 32'h1);
    chk("R3 irq after clear", {31'b0, irq}, 0);
    rd(8'h00, 32'h0, "R3 status cleared");
    @(negedge clk); req = 1; we = 1; addr = 8'h00; wd = 32'h1; be = 4'hf; evt = 1;
    @(negedge clk); req = 0; we = 0; evt = 0;
    chk("R3 set wins", {31'b0, irq}, 1);

    cur_tag = "R4";
    wr(8'h04, 32'hffffffff);
    chk("R4 no error", {31'b0, lerr}, 0);
    rd(8'h04, 32'h0, "R4 mask unchanged");
    cur_tag = "R5";
    wr(8'h0c, 32'h1);
    chk("R5 irq after disable", {31'b0, irq}, 0);
    rd(8'h04, 32'h1, "R5 mask set");
    rd(8'h0c, 32'h0, "R5 disable alias reads 0");
    cur_tag = "R4";
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h1, "R4 mask still set");

    cur_tag = "R11";
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h3f, "R11 pll status constant");

    cur_tag = "R9";
    wr(8'h20, 32'hffffffff);
    wr(8'h24, 32'hffffffff);
    wr(8'h28, 32'hffffffff);
    rd(8'h20, 32'h07737f09, "R9 clk0 reserved");
    rd(8'h24, 32'hfe7fedef, "R9 clk1 reserved");
    rd(8'h28, 32'h013f3f07, "R9 clk2 reserved");
    wr(8'h14, 32'hffffffff);
    chk("R10 no change no pulse", {24'b0, off, on_rst}, 0);
    rd(8'h14, 32'h3d0f, "R9 cluster reserved");

    cur_tag = "R10";
    wr(8'h14, 32'h0);
    chk("R10 power on all", {28'b0, on_rst}, 32'hf);
    chk("R10 no off", {28'b0, off}, 0);
    @(negedge clk);
    chk("R10 single cycle", {24'b0, off, on_rst}, 0);
    wr(8'h14, 32'h5);
    chk("R10 off 0 and 2", {28'b0, off}, 32'h5);
    chk("R10 no on", {28'b0, on_rst}, 0);
    wr(8'h14, 32'h5);
    chk("R10 repeat write silent", {24'b0, off, on_rst}, 0);
    wr(8'h14, 32'h3);
    chk("R10 off core 1", {28'b0, off}, 32'h2);
    chk("R10 on core 2", {28'b0, on_rst}, 32'h4);

    cur_tag = "R6";
    bus(1, 8'h20, 32'h0, 4'h3);
    chk("R6 partial be err", {31'b0, lerr}, 1);
    rd(8'h20, 32'h07737f09, "R6 partial write ignored");
    bus(0, 8'h22, 0, 4'hf);
    chk("R6 misaligned err", {31'b0, lerr}, 1);
    chk("R6 misaligned data", lrd, 0);
    cur_tag = "R7";
    bus(0, 8'h18, 0, 4'hf);
    chk("R7 hole err", {31'b0, lerr}, 1);
    chk("R7 hole data", lrd, 0);
    bus(1, 8'h30, 32'hffffffff, 4'hf);
    chk("R7 write hole err", {31'b0, lerr}, 1);
    cur_tag = "R8";
    wr(8'h24, 32'h0);
    chk("R8 write data zero", lrd, 0);
    repeat (2) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule